// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the register file that sits in front of a descriptor-driven DMA sequencer. It holds one set of registers for each channel: a status word, a 16-byte-aligned command pointer, and three condition-select registers that choose the device-status bits for interrupt, branch and wait decisions. Software reaches it with 32-bit word reads and writes. The word address is `{channel, offset[3:0]}`.

A write to the control offset changes the RUN, PAUSE, FLUSH and WAKE bits under a per-bit mask. The block then works out the channel's ACTIVE state. It sends one-cycle flush and start pulses to the sequencer, and a fetch pulse when a new command pointer is accepted. The sequencer reports back on per-channel strobes: it clears WAKE on a descriptor fetch, ends a flush, sets or clears the branch-taken flag, stops the channel, or marks it dead.

Top module: `dma_csr_bank`

## Requirements
- R1: A control write (offset 0) holds a mask in bits 31:16 and values in bits 15:0. A status bit whose mask bit is clear keeps its value. A control write with a zero mask changes nothing.
- R2: A control write with mask bit 31 set and value bit 15 set sets RUN (status bit 15). With bit 31 set and bit 15 clear, it clears both RUN and DEAD (bit 11), even if a kill arrives in the same cycle.
- R3: When mask bit 30 is set, PAUSE (bit 14) takes value bit 14. After any control write, ACTIVE (bit 10) is 0 if PAUSE is 1 or RUN is 0. ACTIVE is never 1 while RUN is 0 or PAUSE is 1.
- R4: A control write that leaves the channel paused or not running raises `flush_o` for one cycle after the write.
- R5: If RUN=1 and PAUSE=0 after a control write, ACTIVE becomes 1 when the write's mask touches RUN or PAUSE, or when it sets WAKE. In all other cases ACTIVE keeps its value.
- R6: WAKE (bit 12) is set by mask bit 28 with value bit 12 only when RUN is 1 after the write. `seq_fetch_i` clears WAKE.
- R7: Mask bit 29 with value bit 13 sets FLUSH (bit 13) and raises `flush_o` for one cycle. FLUSH stays set until `seq_flush_done_i` clears it.
- R8: `start_o` pulses for one cycle after each control write that leaves ACTIVE at 1, whether ACTIVE has just become 1 or was already 1.
- R9: Offsets 0 and 1 both read the status word `{16'b0, RUN, PAUSE, FLUSH, WAKE, DEAD, ACTIVE, 0, BT, 0000, device status}`. Device status in bits 3:0 is the live value of `dev_stat_i`.
- R10: A write to offset 2 while ACTIVE is 1 is dropped. An accepted write stores the data with bits 3:0 cleared and pulses `fetch_o` for one cycle.
- R11: `seq_kill_i` sets DEAD and clears ACTIVE. `seq_stop_i` clears ACTIVE. `seq_bt_set_i` and `seq_bt_clr_i` set and clear BT (bit 8).
- R12: Offsets 3, 4 and 5 (interrupt, branch and wait select) store bits 19:16 and 3:0 and read zero in every other bit. Every other offset and every absent channel reads zero.
- R13: After reset, every register of every channel reads zero and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write word address {channel, offset} |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read word address {channel, offset} |
| rd_data_o | output | 32 | Read data (combinational) |
| dev_stat_i | input | NUM_CH*4 | Device status nibble per channel |
| seq_fetch_i | input | NUM_CH | Descriptor fetched: clear WAKE |
| seq_flush_done_i | input | NUM_CH | Flush finished: clear FLUSH |
| seq_bt_set_i | input | NUM_CH | Set branch-taken flag |
| seq_bt_clr_i | input | NUM_CH | Clear branch-taken flag |
| seq_stop_i | input | NUM_CH | Stop command: clear ACTIVE |
| seq_kill_i | input | NUM_CH | Fatal error: set DEAD, clear ACTIVE |
| active_o | output | NUM_CH | ACTIVE bit per channel |
| start_o | output | NUM_CH | Start pulse to the sequencer |
| flush_o | output | NUM_CH | Flush request pulse to the device |
| fetch_o | output | NUM_CH | Descriptor fetch pulse after a pointer write |
| cmd_ptr_o | output | NUM_CH*32 | Command pointer per channel |
| int_sel_o | output | NUM_CH*8 | Interrupt select {mask, value} |
| br_sel_o | output | NUM_CH*8 | Branch select {mask, value} |
| wait_sel_o | output | NUM_CH*8 | Wait select {mask, value} |

## Verification
The bench steps one channel through a sequence of control words: run, pause, wake while paused, resume, zero mask, value without mask, stop, and flush while stopped. After each step it checks the status word and both pulses. Each step targets a specific bug. A design that ignores the mask would change bits on the zero-mask write. A design that lets WAKE through while stopped would show bit 12 after the stopped wake write. A design that clears ACTIVE without flushing would leave `flush_o` low on stop.

Directed cases cover the other rules. A pointer write during ACTIVE must leave the stored pointer unchanged and give no fetch. A kill arriving in the same cycle as a stop write must still end with DEAD clear. A wake write with a zero RUN/PAUSE mask must still set ACTIVE. Select registers are written with all ones and must mask off unused bits. A second channel must show its live device nibble and leave channel 0 untouched.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 4;

  typedef enum logic [OFF_W-1:0] {
    OFF_CTL  = 4'd0,
    OFF_STAT = 4'd1,
    OFF_PTR  = 4'd2,
    OFF_ISEL = 4'd3,
    OFF_BSEL = 4'd4,
    OFF_WSEL = 4'd5
  } reg_off_e;

  // control nibble index: mask in wdata[31:28], value in wdata[15:12]
  localparam int C_RUN   = 3;
  localparam int C_PAUSE = 2;
  localparam int C_FLUSH = 1;
  localparam int C_WAKE  = 0;

  typedef struct packed {
    logic run;
    logic pause;
    logic flush;
    logic wake;
    logic dead;
    logic active;
    logic bt;
  } chan_stat_t;

  function automatic logic [DATA_W-1:0] stat_word(chan_stat_t s, logic [3:0] dev);
    return {16'h0, s.run, s.pause, s.flush, s.wake, s.dead, s.active, 1'b0, s.bt, 4'h0, dev};
  endfunction

  function automatic logic [DATA_W-1:0] sel_word(logic [7:0] sel);
    return {12'h0, sel[7:4], 12'h0, sel[3:0]};
  endfunction
endpackage

// File: rtl/dma_csr_ctl.sv
module dma_csr_ctl
  import dma_csr_pkg::*;
(
  input  chan_stat_t cur_i,
  input  logic [3:0] mask_i,
  input  logic [3:0] val_i,
  output chan_stat_t nxt_o,
  output logic       flush_req_o
);
  logic set_wake_req;
  logic flush_set;
  logic halt;

  always_comb begin
    nxt_o = cur_i;
    if (mask_i[C_RUN]) begin
      if (val_i[C_RUN]) begin
        nxt_o.run = 1'b1;
      end else begin
        nxt_o.run  = 1'b0;
        nxt_o.dead = 1'b0;
      end
    end
    set_wake_req = mask_i[C_WAKE] & val_i[C_WAKE];
    if (set_wake_req && nxt_o.run) nxt_o.wake = 1'b1;
    if (mask_i[C_PAUSE]) nxt_o.pause = val_i[C_PAUSE];
    flush_set = mask_i[C_FLUSH] & val_i[C_FLUSH];
    if (flush_set) nxt_o.flush = 1'b1;
    halt = nxt_o.pause | ~nxt_o.run;
    if (halt)                                    nxt_o.active = 1'b0;
    else if (mask_i[C_RUN] || mask_i[C_PAUSE])   nxt_o.active = 1'b1;
    else if (set_wake_req)                       nxt_o.active = 1'b1;
    // a stop drains the device before the channel reports idle
    flush_req_o = halt | flush_set;
  end
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              ptr_we_i,
  input  logic [2:0]        sel_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              seq_fetch_i,
  input  logic              seq_flush_done_i,
  input  logic              seq_bt_set_i,
  input  logic              seq_bt_clr_i,
  input  logic              seq_stop_i,
  input  logic              seq_kill_i,
  output chan_stat_t        stat_o,
  output logic [DATA_W-1:0] cmd_ptr_o,
  output logic [7:0]        sel_o [3],
  output logic              start_o,
  output logic              flush_o,
  output logic              fetch_o
);
  chan_stat_t stat_q, stat_seq, stat_ctl;
  logic       ctl_flush;
  logic [DATA_W-1:0] ptr_q;
  logic [7:0] sel_q [3];

  always_comb begin
    stat_seq = stat_q;
    if (seq_fetch_i)      stat_seq.wake   = 1'b0;
    if (seq_flush_done_i) stat_seq.flush  = 1'b0;
    if (seq_bt_set_i)     stat_seq.bt     = 1'b1;
    if (seq_bt_clr_i)     stat_seq.bt     = 1'b0;
    if (seq_stop_i)       stat_seq.active = 1'b0;
    if (seq_kill_i) begin
      stat_seq.dead   = 1'b1;
      stat_seq.active = 1'b0;
    end
  end

  dma_csr_ctl u_ctl (
    .cur_i       (stat_seq),
    .mask_i      (wdata_i[31:28]),
    .val_i       (wdata_i[15:12]),
    .nxt_o       (stat_ctl),
    .flush_req_o (ctl_flush)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      ptr_q   <= '0;
      start_o <= 1'b0;
      flush_o <= 1'b0;
      fetch_o <= 1'b0;
    end else begin
      stat_q  <= ctl_we_i ? stat_ctl : stat_seq;
      start_o <= ctl_we_i & stat_ctl.active;
      flush_o <= ctl_we_i & ctl_flush;
      fetch_o <= ptr_we_i & ~stat_q.active;
      if (ptr_we_i && !stat_q.active) ptr_q <= {wdata_i[DATA_W-1:4], 4'h0};
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          sel_q[k] <= '0;
      else if (sel_we_i[k]) sel_q[k] <= {wdata_i[19:16], wdata_i[3:0]};
    end
    assign sel_o[k] = sel_q[k];
  end

  assign stat_o    = stat_q;
  assign cmd_ptr_o = ptr_q;

  a_r3_active_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q.active |-> (stat_q.run && !stat_q.pause));
  a_r10_ptr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q[3:0] == 4'h0);
  a_r10_ptr_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_i && stat_q.active) |=> ($stable(ptr_q) && !fetch_o));
  a_r4_stop_flushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && wdata_i[31] && !wdata_i[15]) |=> (flush_o && !stat_q.active));
  a_r2_stop_clears_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && wdata_i[31] && !wdata_i[15]) |=> (!stat_q.dead && !stat_q.run));
  a_r7_flush_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && wdata_i[29] && wdata_i[13]) |=> (flush_o && stat_q.flush));
  a_r8_start_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> stat_q.active);
  a_r11_kill_sets_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_kill_i && !ctl_we_i) |=> (stat_q.dead && !stat_q.active));
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + OFF_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic [NUM_CH*4-1:0]  dev_stat_i,
  input  logic [NUM_CH-1:0]    seq_fetch_i,
  input  logic [NUM_CH-1:0]    seq_flush_done_i,
  input  logic [NUM_CH-1:0]    seq_bt_set_i,
  input  logic [NUM_CH-1:0]    seq_bt_clr_i,
  input  logic [NUM_CH-1:0]    seq_stop_i,
  input  logic [NUM_CH-1:0]    seq_kill_i,
  output logic [NUM_CH-1:0]    active_o,
  output logic [NUM_CH-1:0]    start_o,
  output logic [NUM_CH-1:0]    flush_o,
  output logic [NUM_CH-1:0]    fetch_o,
  output logic [NUM_CH*32-1:0] cmd_ptr_o,
  output logic [NUM_CH*8-1:0]  int_sel_o,
  output logic [NUM_CH*8-1:0]  br_sel_o,
  output logic [NUM_CH*8-1:0]  wait_sel_o
);
  logic [CH_W-1:0]  wr_ch, rd_ch;
  logic [OFF_W-1:0] wr_off, rd_off;
  chan_stat_t        stat_w [NUM_CH];
  logic [DATA_W-1:0] ptr_w  [NUM_CH];
  logic [7:0]        sel_w  [NUM_CH][3];

  assign wr_ch  = wr_addr_i[ADDR_W-1:OFF_W];
  assign wr_off = wr_addr_i[OFF_W-1:0];
  assign rd_ch  = rd_addr_i[ADDR_W-1:OFF_W];
  assign rd_off = rd_addr_i[OFF_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    logic [2:0] sel_we;
    assign hit    = wr_en_i && (int'(wr_ch) == c);
    assign sel_we = {hit && wr_off == OFF_WSEL, hit && wr_off == OFF_BSEL, hit && wr_off == OFF_ISEL};

    dma_csr_chan u_chan (
      .clk_i            (clk_i),
      .rst_ni           (rst_ni),
      .ctl_we_i         (hit && wr_off == OFF_CTL),
      .ptr_we_i         (hit && wr_off == OFF_PTR),
      .sel_we_i         (sel_we),
      .wdata_i          (wr_data_i),
      .seq_fetch_i      (seq_fetch_i[c]),
      .seq_flush_done_i (seq_flush_done_i[c]),
      .seq_bt_set_i     (seq_bt_set_i[c]),
      .seq_bt_clr_i     (seq_bt_clr_i[c]),
      .seq_stop_i       (seq_stop_i[c]),
      .seq_kill_i       (seq_kill_i[c]),
      .stat_o           (stat_w[c]),
      .cmd_ptr_o        (ptr_w[c]),
      .sel_o            (sel_w[c]),
      .start_o          (start_o[c]),
      .flush_o          (flush_o[c]),
      .fetch_o          (fetch_o[c])
    );

    assign active_o[c]             = stat_w[c].active;
    assign cmd_ptr_o[c*32 +: 32]   = ptr_w[c];
    assign int_sel_o[c*8 +: 8]     = sel_w[c][0];
    assign br_sel_o[c*8 +: 8]      = sel_w[c][1];
    assign wait_sel_o[c*8 +: 8]    = sel_w[c][2];
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_ch) < NUM_CH) begin
      case (reg_off_e'(rd_off))
        OFF_CTL, OFF_STAT: rd_data_o = stat_word(stat_w[rd_ch], dev_stat_i[int'(rd_ch)*4 +: 4]);
        OFF_PTR:           rd_data_o = ptr_w[rd_ch];
        OFF_ISEL:          rd_data_o = sel_word(sel_w[rd_ch][0]);
        OFF_BSEL:          rd_data_o = sel_word(sel_w[rd_ch][1]);
        OFF_WSEL:          rd_data_o = sel_word(sel_w[rd_ch][2]);
        default:           rd_data_o = '0;
      endcase
    end
  end

  a_r12_absent_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_off > 4'd5) |-> (rd_data_o == '0));
  a_r9_status_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_off == 4'd0) |-> (rd_data_o[31:16] == 16'h0));
endmodule

// File: tb/sim_dma_csr_bank.sv
module sim_dma_csr_bank;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0] dev_stat = '0;
  logic [1:0] sq_fetch = '0, sq_fdone = '0, sq_bts = '0, sq_btc = '0, sq_stop = '0, sq_kill = '0;
  logic [1:0] active, start, flush, fetch;
  logic [63:0] cmd_ptr;
  logic [15:0] isel, bsel, wsel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_csr_bank #(.NUM_CH(NUM_CH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .dev_stat_i(dev_stat),
    .seq_fetch_i(sq_fetch), .seq_flush_done_i(sq_fdone), .seq_bt_set_i(sq_bts),
    .seq_bt_clr_i(sq_btc), .seq_stop_i(sq_stop), .seq_kill_i(sq_kill),
    .active_o(active), .start_o(start), .flush_o(flush), .fetch_o(fetch),
    .cmd_ptr_o(cmd_ptr), .int_sel_o(isel), .br_sel_o(bsel), .wait_sel_o(wsel)
  );

  // {control word, expected status, expected start, expected flush}
  localparam logic [49:0] VEC [8] = '{
    {32'h8000_8000, 16'h8400, 1'b1, 1'b0},
    {32'h4000_4000, 16'hC000, 1'b0, 1'b1},
    {32'h1000_1000, 16'hD000, 1'b0, 1'b1},
    {32'h4000_0000, 16'h9400, 1'b1, 1'b0},
    {32'h0000_0000, 16'h9400, 1'b1, 1'b0},
    {32'h0000_8000, 16'h9400, 1'b1, 1'b0},
    {32'h8000_0000, 16'h1000, 1'b0, 1'b1},
    {32'h2000_2000, 16'h3000, 1'b0, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {ch, off}; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic ch, input logic [3:0] off, output logic [31:0] d);
    rd_addr = {ch, off};
    #1 d = rd_data;
  endtask

  task automatic pulse_seq(input int which, input logic ch);
    @(negedge clk);
    case (which)
      0: sq_fetch[ch] = 1'b1;
      1: sq_fdone[ch] = 1'b1;
      2: sq_bts[ch]   = 1'b1;
      3: sq_btc[ch]   = 1'b1;
      4: sq_stop[ch]  = 1'b1;
      default: sq_kill[ch] = 1'b1;
    endcase
    @(posedge clk);
    @(negedge clk);
    sq_fetch = '0; sq_fdone = '0; sq_bts = '0; sq_btc = '0; sq_stop = '0; sq_kill = '0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R13 reset state
    for (int o = 0; o < 6; o++) begin
      rd(1'b0, 4'(o), v); chk("R13 reset reg", v, 32'h0);
    end
    chk("R13 reset pulses", {28'h0, start, flush}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 R8 control table on channel 0
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, 4'd0, VEC[i][49:18]);
      chk("R8 start pulse", {31'h0, start[0]}, {31'h0, VEC[i][1]});
      chk("R4 flush pulse", {31'h0, flush[0]}, {31'h0, VEC[i][0]});
      rd(1'b0, 4'd1, v);
      chk("R1 R5 status after ctl write", v, {16'h0, VEC[i][17:2]});
    end
    @(negedge clk);
    chk("R8 start single cycle", {31'h0, start[0]}, 32'h0);

    // R7 flush done clears FLUSH; R6 fetch clears WAKE
    pulse_seq(1, 1'b0);
    rd(1'b0, 4'd1, v); chk("R7 flush cleared", v, 32'h1000);
    pulse_seq(0, 1'b0);
    rd(1'b0, 4'd1, v); chk("R6 wake cleared by fetch", v, 32'h0);
    // R6 wake ignored while stopped
    wr(1'b0, 4'd0, 32'h1000_1000);
    rd(1'b0, 4'd1, v); chk("R6 wake ignored without run", v, 32'h0);
    chk("R4 stopped write flushes", {31'h0, flush[0]}, 32'h1);

    // R10 command pointer
    wr(1'b0, 4'd2, 32'h1234_5678);
    chk("R10 fetch pulse", {31'h0, fetch[0]}, 32'h1);
    rd(1'b0, 4'd2, v); chk("R10 aligned pointer", v, 32'h1234_5670);
    wr(1'b0, 4'd0, 32'h8000_8000);
    wr(1'b0, 4'd2, 32'hABCD_EF00);
    chk("R10 no fetch while active", {31'h0, fetch[0]}, 32'h0);
    rd(1'b0, 4'd2, v); chk("R10 pointer locked", v, 32'h1234_5670);

    // R11 sequencer updates
    pulse_seq(2, 1'b0);
    rd(1'b0, 4'd1, v); chk("R11 bt set", v, 32'h8500);
    pulse_seq(3, 1'b0);
    rd(1'b0, 4'd1, v); chk("R11 bt clear", v, 32'h8400);
    pulse_seq(5, 1'b0);
    rd(1'b0, 4'd0, v); chk("R11 R9 kill via ctl offset", v, 32'h8800);
    wr(1'b0, 4'd0, 32'h0000_0000);
    rd(1'b0, 4'd1, v); chk("R1 zero mask keeps inactive", v, 32'h8800);
    chk("R8 no start when inactive", {31'h0, start[0]}, 32'h0);
    wr(1'b0, 4'd0, 32'h1000_1000);
    rd(1'b0, 4'd1, v); chk("R5 wake reactivates", v, 32'h9C00);
    chk("R8 start on wake", {31'h0, start[0]}, 32'h1);
    pulse_seq(4, 1'b0);
    rd(1'b0, 4'd1, v); chk("R11 stop clears active", v, 32'h9800);

    // R2 stop write wins over simultaneous kill
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {1'b0, 4'd0}; wr_data = 32'h8000_0000; sq_kill[0] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; sq_kill = '0;
    rd(1'b0, 4'd1, v); chk("R2 dead cleared over kill", v, 32'h1000);

    // R12 select and unused registers
    wr(1'b0, 4'd3, 32'hFFFF_FFFF);
    rd(1'b0, 4'd3, v); chk("R12 interrupt select", v, 32'h000F_000F);
    chk("R12 interrupt select port", {24'h0, isel[7:0]}, 32'hFF);
    wr(1'b0, 4'd4, 32'h0005_0003);
    rd(1'b0, 4'd4, v); chk("R12 branch select", v, 32'h0005_0003);
    chk("R12 branch select port", {24'h0, bsel[7:0]}, 32'h53);
    wr(1'b0, 4'd7, 32'hFFFF_FFFF);
    rd(1'b0, 4'd7, v); chk("R12 unused reads zero", v, 32'h0);

    // R9 second channel with live device status
    dev_stat = 8'hA0;
    wr(1'b1, 4'd0, 32'h8000_8000);
    chk("R8 start on channel 1 only", {30'h0, start}, 32'h2);
    rd(1'b1, 4'd1, v); chk("R9 channel 1 status with device bits", v, 32'h840A);
    rd(1'b0, 4'd1, v); chk("R1 channel 0 untouched", v, 32'h1000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule